// File: doc/BRIEF.md
# Power Domain Shutdown and Wake-up Sequencer

This block takes one power domain safely between its on and off states. A power-down runs in this order: a context-save handshake, then the domain's bus interface is brought to a quiescent state through an idle request, its acknowledge and its idle status, and only then is power removed and the block waits for the power status to confirm it. A power-up runs the reverse: power is applied and confirmed, the idle request is released and its acknowledge and idle status are seen to clear, and then a context-restore handshake runs. When a sequence ends, the block raises a single-cycle done pulse.

Commands arrive on a valid/ready pair. `cmd_ready` is high only while the sequencer is idle. A command with `cmd_valid` high in a cycle where `cmd_ready` is high is consumed at that clock edge. While a sequence runs, `cmd_ready` stays low, and a command held on the port waits until the sequencer is idle again. Two build parameters describe which controls the domain has. A domain without a power-control bit is idle-only: its "on" state is defined as "not idle". A domain without an idle-request bit skips the bus handshake.

Every wait step has a timeout that software can set. When a timeout expires, a sticky error flag is set and the sequencer returns to idle without a done pulse.

Top module: `pwr_seq_top`

## Requirements
- R1: After reset, `pwr_ctl`, `idle_req`, `save_req`, `restore_req`, `busy`, `done` and `err` are 0 and `cmd_ready` is 1. A reset also clears `err`.
- R2: Power-down order: `save_req` is held until `save_ack`. Then `idle_req` goes to 1, the block waits for `idle_ack`=1 and then for `idle_stat`=1. Then `pwr_ctl` goes to 1 and the block waits for `pwr_stat`=1.
- R3: Power-up order: `pwr_ctl` goes to 0 and the block waits for `pwr_stat`=0. Then `idle_req` goes to 0, the block waits for `idle_ack`=0 and then for `idle_stat`=0. Then `restore_req` is held until `restore_ack`.
- R4: Polarity: `pwr_ctl`=1 commands off and `pwr_stat`=1 reports off. `cmd_on`=1 requests the on state and `cmd_on`=0 requests off.
- R5: With `HAS_REQ`=0, `idle_req` never leaves 0 and the idle handshake steps are skipped.
- R6: With `HAS_PWR`=0, `pwr_ctl` never leaves 0, the power step is skipped, and the current state is on exactly when `idle_stat`=0.
- R7: A command whose target equals the current state is consumed. It starts no sequence: `busy` stays 0, no done pulse appears and no control output changes.
- R8: `cmd_ready` is 0 from the edge that accepts a command until the sequence ends. A command presented during that time is not taken.
- R9: `done` is high for exactly one cycle after the last step of a sequence completes. After that cycle, `busy` falls.
- R10: When `tmo_limit` is nonzero and a wait step sees its condition false on `tmo_limit` consecutive edges, `err` is set and stays set, and the sequencer returns to idle with no done pulse. A `tmo_limit` of 0 disables the timeout.
- R11: `dom_on` reports the present state: it is `!pwr_stat` when `HAS_PWR`=1 and `!idle_stat` otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Sequencer idle and able to take a command |
| cmd_on | input | 1 | Target state: 1 = on, 0 = off |
| tmo_limit | input | TMO_W | Wait timeout in cycles; 0 disables it |
| pwr_ctl | output | 1 | Power switch control, 1 = off |
| pwr_stat | input | 1 | Power status, 1 = off |
| idle_req | output | 1 | Bus idle request |
| idle_ack | input | 1 | Bus idle acknowledge |
| idle_stat | input | 1 | Bus idle status |
| save_req | output | 1 | Context-save request |
| save_ack | input | 1 | Context-save finished |
| restore_req | output | 1 | Context-restore request |
| restore_ack | input | 1 | Context-restore finished |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle pulse at the end of a sequence |
| err | output | 1 | Sticky timeout error |
| dom_on | output | 1 | Present domain state, 1 = on |

## Verification
The bench builds three copies of the block side by side: one with both control bits, one idle-only (`HAS_PWR`=0) and one power-only (`HAS_REQ`=0). Together they reach every skip path of the step list and both definitions of the "on" state. Each copy is driven by a behavioural domain model whose response latency can be changed, including a latency longer than any timeout and a stuck mode that forces a timeout at the first wait step. The copies see both a timeout of 0 and nonzero timeouts.

// File: rtl/pwr_seq_pkg.sv
package pwr_seq_pkg;

  // Sequencer steps; every state other than ST_IDLE and ST_DONE is a wait step.
  typedef enum logic [3:0] {
    ST_IDLE    = 4'd0,
    ST_SAVE    = 4'd1,
    ST_REQ_ACK = 4'd2,
    ST_REQ_IDL = 4'd3,
    ST_PWR     = 4'd4,
    ST_REL_ACK = 4'd5,
    ST_REL_IDL = 4'd6,
    ST_RESTORE = 4'd7,
    ST_DONE    = 4'd8
  } seq_st_e;

endpackage

// File: rtl/pwr_seq_timer.sv
module pwr_seq_timer #(
  parameter int TMO_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             active,
  input  logic             met,
  input  logic             step,
  input  logic [TMO_W-1:0] limit,
  output logic             expire
);

  localparam logic [TMO_W-1:0] ONE = {{(TMO_W-1){1'b0}}, 1'b1};

  logic [TMO_W-1:0] cnt_q;

  // Counts the edges spent in the current wait step; restarts on every step change.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (!active || step) begin
      cnt_q <= '0;
    end else if (cnt_q != {TMO_W{1'b1}}) begin
      cnt_q <= cnt_q + ONE;
    end
  end

  assign expire = active && !met && (limit != '0) && (cnt_q == limit - ONE);

endmodule

// File: rtl/pwr_seq_fsm.sv
module pwr_seq_fsm
  import pwr_seq_pkg::*;
#(
  parameter bit HAS_PWR = 1'b1,
  parameter bit HAS_REQ = 1'b1
) (
  input  seq_st_e st,
  input  logic    go,
  input  logic    down,
  input  logic    pwr_stat,
  input  logic    idle_ack,
  input  logic    idle_stat,
  input  logic    save_ack,
  input  logic    restore_ack,
  input  logic    expire,
  output logic    met,
  output seq_st_e nxt
);

  // Successor steps, chosen once from the domain's capabilities.
  localparam seq_st_e DN_AFTER_SAVE = HAS_REQ ? ST_REQ_ACK : (HAS_PWR ? ST_PWR : ST_DONE);
  localparam seq_st_e DN_AFTER_IDL  = HAS_PWR ? ST_PWR : ST_DONE;
  localparam seq_st_e UP_FIRST      = HAS_PWR ? ST_PWR : (HAS_REQ ? ST_REL_ACK : ST_RESTORE);
  localparam seq_st_e UP_AFTER_PWR  = HAS_REQ ? ST_REL_ACK : ST_RESTORE;

  always_comb begin
    unique case (st)
      ST_SAVE:    met = save_ack;
      ST_REQ_ACK: met = idle_ack;
      ST_REQ_IDL: met = idle_stat;
      ST_PWR:     met = (pwr_stat == down);
      ST_REL_ACK: met = !idle_ack;
      ST_REL_IDL: met = !idle_stat;
      ST_RESTORE: met = restore_ack;
      default:    met = 1'b0;
    endcase
  end

  always_comb begin
    nxt = st;
    if (st == ST_IDLE) begin
      if (go) nxt = down ? ST_SAVE : UP_FIRST;
    end else if (st == ST_DONE) begin
      nxt = ST_IDLE;
    end else if (met) begin
      unique case (st)
        ST_SAVE:    nxt = DN_AFTER_SAVE;
        ST_REQ_ACK: nxt = ST_REQ_IDL;
        ST_REQ_IDL: nxt = DN_AFTER_IDL;
        ST_PWR:     nxt = down ? ST_DONE : UP_AFTER_PWR;
        ST_REL_ACK: nxt = ST_REL_IDL;
        ST_REL_IDL: nxt = ST_RESTORE;
        ST_RESTORE: nxt = ST_DONE;
        default:    nxt = ST_IDLE;
      endcase
    end else if (expire) begin
      nxt = ST_IDLE;
    end
  end

endmodule

// File: rtl/pwr_seq_top.sv
module pwr_seq_top
  import pwr_seq_pkg::*;
#(
  parameter bit HAS_PWR = 1'b1,
  parameter bit HAS_REQ = 1'b1,
  parameter int TMO_W   = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  output logic             cmd_ready,
  input  logic             cmd_on,
  input  logic [TMO_W-1:0] tmo_limit,
  output logic             pwr_ctl,
  input  logic             pwr_stat,
  output logic             idle_req,
  input  logic             idle_ack,
  input  logic             idle_stat,
  output logic             save_req,
  input  logic             save_ack,
  output logic             restore_req,
  input  logic             restore_ack,
  output logic             busy,
  output logic             done,
  output logic             err,
  output logic             dom_on
);

  seq_st_e st_q, st_d;
  logic    dir_q, dir_d;
  logic    cur_on, go, met, expire, active, step;
  logic    idle_req_q, pwr_ctl_q, err_q;

  // Present state: an idle-only domain counts as on while it is not idle.
  assign cur_on = HAS_PWR ? !pwr_stat : !idle_stat;
  assign dir_d  = (st_q == ST_IDLE) ? !cmd_on : dir_q;
  assign go     = cmd_valid && (st_q == ST_IDLE) && (cmd_on != cur_on);
  assign active = (st_q != ST_IDLE) && (st_q != ST_DONE);
  assign step   = (st_d != st_q);

  pwr_seq_fsm #(
    .HAS_PWR(HAS_PWR),
    .HAS_REQ(HAS_REQ)
  ) u_fsm (
    .st         (st_q),
    .go         (go),
    .down       (dir_d),
    .pwr_stat   (pwr_stat),
    .idle_ack   (idle_ack),
    .idle_stat  (idle_stat),
    .save_ack   (save_ack),
    .restore_ack(restore_ack),
    .expire     (expire),
    .met        (met),
    .nxt        (st_d)
  );

  pwr_seq_timer #(
    .TMO_W(TMO_W)
  ) u_tmr (
    .clk   (clk),
    .rst_n (rst_n),
    .active(active),
    .met   (met),
    .step  (step),
    .limit (tmo_limit),
    .expire(expire)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q       <= ST_IDLE;
      dir_q      <= 1'b0;
      idle_req_q <= 1'b0;
      pwr_ctl_q  <= 1'b0;
      err_q      <= 1'b0;
    end else begin
      st_q  <= st_d;
      dir_q <= dir_d;
      if (step && st_d == ST_REQ_ACK) idle_req_q <= 1'b1;
      if (step && st_d == ST_REL_ACK) idle_req_q <= 1'b0;
      if (step && st_d == ST_PWR)     pwr_ctl_q  <= dir_d;
      if (expire)                     err_q      <= 1'b1;
    end
  end

  assign pwr_ctl     = pwr_ctl_q;
  assign idle_req    = idle_req_q;
  assign save_req    = (st_q == ST_SAVE);
  assign restore_req = (st_q == ST_RESTORE);
  assign busy        = (st_q != ST_IDLE);
  assign cmd_ready   = (st_q == ST_IDLE);
  assign done        = (st_q == ST_DONE);
  assign err         = err_q;
  assign dom_on      = cur_on;

endmodule

// File: rtl/pwr_seq_chk.sv
module pwr_seq_chk #(
  parameter bit HAS_PWR = 1'b1,
  parameter bit HAS_REQ = 1'b1
) (
  input logic clk,
  input logic rst_n,
  input logic cmd_valid,
  input logic cmd_ready,
  input logic pwr_ctl,
  input logic pwr_stat,
  input logic idle_req,
  input logic idle_stat,
  input logic save_ack,
  input logic restore_req,
  input logic busy,
  input logic done,
  input logic err
);

  p_save_before_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(idle_req) |-> $past(save_ack));

  p_off_after_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (HAS_REQ && $rose(pwr_ctl)) |-> $past(idle_stat));

  p_release_after_on_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (HAS_PWR && $fell(idle_req)) |-> $past(!pwr_stat));

  p_restore_released_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(restore_req) |-> !idle_req);

  p_no_req_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !HAS_REQ |-> !idle_req);

  p_no_pwr_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !HAS_PWR |-> !pwr_ctl);

  p_accept_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(cmd_valid && cmd_ready));

  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && !busy));

  p_err_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> err);

endmodule

bind pwr_seq_top pwr_seq_chk #(
  .HAS_PWR(HAS_PWR),
  .HAS_REQ(HAS_REQ)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cmd_valid  (cmd_valid),
  .cmd_ready  (cmd_ready),
  .pwr_ctl    (pwr_ctl),
  .pwr_stat   (pwr_stat),
  .idle_req   (idle_req),
  .idle_stat  (idle_stat),
  .save_ack   (save_ack),
  .restore_req(restore_req),
  .busy       (busy),
  .done       (done),
  .err        (err)
);

// File: tb/sim_pwr_seq_top.sv
`timescale 1ns/1ps

module sim_lane #(
  parameter bit HP = 1'b1,
  parameter bit HR = 1'b1
) (
  input logic clk
);

  logic rst_n, cmd_valid, cmd_ready, cmd_on;
  logic [15:0] tmo;
  logic pwr_ctl, pwr_stat, idle_req, idle_ack, idle_stat;
  logic save_req, save_ack, restore_req, restore_ack;
  logic busy, done, err, dom_on;

  int  n_chk = 0, n_bad = 0, n_done = 0;
  bit  fin = 0;
  int  lat = 2;
  bit  stuck = 0;
  bit  seen_req = 0, seen_pwr = 0;

  pwr_seq_top #(.HAS_PWR(HP), .HAS_REQ(HR), .TMO_W(16)) u0 (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_on(cmd_on), .tmo_limit(tmo), .pwr_ctl(pwr_ctl), .pwr_stat(pwr_stat),
    .idle_req(idle_req), .idle_ack(idle_ack), .idle_stat(idle_stat),
    .save_req(save_req), .save_ack(save_ack), .restore_req(restore_req),
    .restore_ack(restore_ack), .busy(busy), .done(done), .err(err), .dom_on(dom_on)
  );

  // Behavioural domain: every response follows its request after lat edges.
  int ca, ci, cp, cs, cr;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pwr_stat <= 0; idle_ack <= 0; idle_stat <= 0; save_ack <= 0; restore_ack <= 0;
      ca = 0; ci = 0; cp = 0; cs = 0; cr = 0;
    end else if (!stuck) begin
      if (idle_ack != idle_req) begin
        if (ca >= lat) begin idle_ack <= idle_req; ca = 0; end else ca++;
      end else ca = 0;
      if (idle_stat != idle_ack) begin
        if (ci >= lat) begin idle_stat <= idle_ack; ci = 0; end else ci++;
      end else ci = 0;
      if (pwr_stat != pwr_ctl) begin
        if (cp >= lat) begin pwr_stat <= pwr_ctl; cp = 0; end else cp++;
      end else cp = 0;
      if (save_req && !save_ack) begin
        if (cs >= lat) begin save_ack <= 1; cs = 0; end else cs++;
      end else begin save_ack <= 0; cs = 0; end
      if (restore_req && !restore_ack) begin
        if (cr >= lat) begin restore_ack <= 1; cr = 0; end else cr++;
      end else begin restore_ack <= 0; cr = 0; end
    end
  end

  // Reference model: a list of pending steps (1 save, 2 req/ack, 3 req/idle,
  // 4 power, 5 release/ack, 6 release/idle, 7 restore, 8 done pulse).
  int q[$];
  int wt = 0;
  bit e_req = 0, e_pwr = 0, e_err = 0, e_dir = 0;

  function automatic bit step_ok(int h);
    case (h)
      1: return save_ack;
      2: return idle_ack;
      3: return idle_stat;
      4: return pwr_stat == e_dir;
      5: return !idle_ack;
      6: return !idle_stat;
      7: return restore_ack;
      default: return 0;
    endcase
  endfunction

  function automatic void enter();
    wt = 0;
    if (q.size() > 0) begin
      if (q[0] == 2) e_req = 1;
      if (q[0] == 5) e_req = 0;
      if (q[0] == 4) e_pwr = e_dir;
    end
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      q.delete(); wt = 0; e_req = 0; e_pwr = 0; e_err = 0; e_dir = 0;
    end else if (q.size() == 0) begin
      if (cmd_valid && (cmd_on != (HP ? !pwr_stat : !idle_stat))) begin
        e_dir = !cmd_on;
        if (e_dir) begin
          q.push_back(1);
          if (HR) begin q.push_back(2); q.push_back(3); end
          if (HP) q.push_back(4);
        end else begin
          if (HP) q.push_back(4);
          if (HR) begin q.push_back(5); q.push_back(6); end
          q.push_back(7);
        end
        q.push_back(8);
        enter();
      end
    end else if (q[0] == 8) begin
      void'(q.pop_front());
    end else if (step_ok(q[0])) begin
      void'(q.pop_front());
      enter();
    end else begin
      wt++;
      if (tmo != 0 && wt >= int'(tmo)) begin e_err = 1; q.delete(); end
    end
  end

  task automatic cmp(bit act, bit exp, string tag, string nm);
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d t=%0t", tag, nm, act, exp, $time);
    end
  endtask

  // Per-cycle comparison against the model, away from the active edge.
  bit pwr_prev = 0, rst_prev = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      bit eb;
      eb = q.size() > 0;
      n_chk++;
      cmp(idle_req, e_req, "R2", "idle_req");
      cmp(pwr_ctl, e_pwr, "R4", "pwr_ctl");
      cmp(busy, eb, "R8", "busy");
      cmp(cmd_ready, !eb, "R8", "cmd_ready");
      cmp(done, eb && q[0] == 8, "R9", "done");
      cmp(err, e_err, "R10", "err");
      cmp(save_req, eb && q[0] == 1, "R2", "save_req");
      cmp(restore_req, eb && q[0] == 7, "R3", "restore_req");
      cmp(dom_on, HP ? !pwr_stat : !idle_stat, "R11", "dom_on");
      if (done) n_done++;
      if (idle_req) seen_req = 1;
      if (pwr_ctl) seen_pwr = 1;
      // R2: power removed only once the bus reports idle
      if (HR && pwr_ctl && !pwr_prev && rst_prev) begin
        n_chk++;
        if (!(idle_req && idle_stat)) begin
          n_bad++;
          $display("FAIL R2 power off before idle actual=%0d expected=1", idle_stat);
        end
      end
      // R3: restore only after release is confirmed and power is on
      if (restore_req && !restore_ack && !$past(restore_req)) begin
        n_chk++;
        if (idle_req || idle_stat || (HP && pwr_stat)) begin
          n_bad++;
          $display("FAIL R3 restore too early actual=%0d expected=0", idle_stat);
        end
      end
    end
    pwr_prev = pwr_ctl;
    rst_prev = rst_n;
  end

  task automatic chk(bit ok, string tag, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic send(bit on);
    @(negedge clk);
    cmd_valid = 1; cmd_on = on;
    @(negedge clk);
    cmd_valid = 0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 3000 && busy; i++) @(negedge clk);
  endtask

  initial begin
    int nd;
    rst_n = 0; cmd_valid = 0; cmd_on = 0; tmo = 16;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk(!pwr_ctl && !idle_req && !save_req && !restore_req, "R1 controls", pwr_ctl, 0);
    chk(!busy && !done && !err && cmd_ready, "R1 status", busy, 0);
    chk(dom_on, "R11 on after reset", dom_on, 1);

    send(0); wait_idle(); @(negedge clk);
    chk(!dom_on, "R11 off after power-down", dom_on, 0);
    chk(pwr_ctl == HP, "R4 pwr_ctl off level", pwr_ctl, HP);
    chk(idle_req == HR, "R2 idle_req held", idle_req, HR);
    chk(n_done == 1, "R9 one done pulse", n_done, 1);

    nd = n_done;
    send(0); repeat (5) @(negedge clk);
    chk(!busy && n_done == nd && pwr_ctl == HP, "R7 redundant off ignored", n_done, nd);

    send(1); wait_idle(); @(negedge clk);
    chk(dom_on && !pwr_ctl && !idle_req, "R3 power-up result", dom_on, 1);
    chk(n_done == 2, "R9 second done pulse", n_done, 2);

    // R8: a command held during a sequence is not taken
    @(negedge clk); cmd_valid = 1; cmd_on = 0;
    @(negedge clk); cmd_on = 1;
    chk(!cmd_ready, "R8 ready low while busy", cmd_ready, 0);
    repeat (2) @(negedge clk);
    chk(!cmd_ready && busy, "R8 still busy", busy, 1);
    cmd_valid = 0;
    wait_idle(); @(negedge clk);
    chk(!dom_on, "R8 held up command dropped", dom_on, 0);

    lat = 0;
    send(1); wait_idle(); @(negedge clk);
    chk(dom_on, "R3 fast domain up", dom_on, 1);

    // R10: limit 0 never times out even on a slow domain
    tmo = 0; lat = 25;
    send(0); wait_idle(); @(negedge clk);
    chk(!err && !dom_on, "R10 timeout disabled", err, 0);
    lat = 2; tmo = 16;
    send(1); wait_idle(); @(negedge clk);

    // R10: stuck domain times out
    nd = n_done; tmo = 5; stuck = 1;
    send(0); wait_idle(); @(negedge clk);
    chk(err, "R10 timeout sets err", err, 1);
    chk(n_done == nd && !busy, "R10 no done on timeout", n_done, nd);
    repeat (4) @(negedge clk);
    chk(err, "R10 err sticky", err, 1);

    rst_n = 0; stuck = 0;
    repeat (2) @(negedge clk);
    rst_n = 1; @(negedge clk);
    chk(!err && cmd_ready, "R1 reset clears err", err, 0);

    if (!HR) chk(!seen_req, "R5 idle_req never raised", seen_req, 0);
    if (!HP) chk(!seen_pwr, "R6 pwr_ctl never raised", seen_pwr, 0);
    fin = 1;
  end

endmodule

module sim_pwr_seq_top;

  logic clk = 0;
  always #2 clk = ~clk;

  sim_lane #(.HP(1'b1), .HR(1'b1)) l_full (.clk(clk));
  sim_lane #(.HP(1'b0), .HR(1'b1)) l_idle (.clk(clk));
  sim_lane #(.HP(1'b1), .HR(1'b0)) l_pwr  (.clk(clk));

  initial begin
    int cyc, tot, bad;
    cyc = 0;
    while (!(l_full.fin && l_idle.fin && l_pwr.fin) && cyc < 150000) begin
      @(posedge clk);
      cyc++;
    end
    tot = l_full.n_chk + l_idle.n_chk + l_pwr.n_chk;
    bad = l_full.n_bad + l_idle.n_bad + l_pwr.n_bad;
    if (cyc >= 150000) begin
      tot++; bad++;
      $display("FAIL watchdog actual=%0d expected=<150000", cyc);
    end
    $display("%0d/%0d checks passed", tot - bad, tot);
    $finish;
  end

endmodule